// File: doc/BRIEF.md
# Attribute Delay and Glyph Address Sequencer

This block sits between a character row buffer and a dot/attribute generator. It runs on the system clock, and a one-cycle `tick` enable marks each character time. A byte taken from the row buffer is held in a code latch together with its two attribute bits. These are blink and background.

On every tick the block does two things. First, it pushes the blink bit, the background bit and a composite blank input through three identical short shift lines, so that they line up with the pixel data further down the pipe. Second, it updates a 4-bit scanline number that is assembled serially from a data line qualified by a gate. It then reads one glyph byte from a pattern RAM. The RAM address is the latched character code times sixteen plus the scanline number.

A CPU writes glyph patterns into the RAM through a separate write port on the same clock.

Top module: `glyph_tick_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge: `blink_out`, `bkgnd_out`, `blank_out`, `glyph_byte` and `glyph_valid`.
- R2: `row_attr[0]` (blink) and `row_attr[1]` (background) are held in the attribute latch. Each delay line has three stages. On every tick the output register takes stage 0, stages 2..1 shift down one place, and stage 2 takes the current latch value. A latch value sampled on tick n therefore shows on `blink_out`/`bkgnd_out` from tick n+3 onward.
- R3: `comp_blank` is sampled directly on each tick and passes through the same three-stage structure to `blank_out`.
- R4: In a cycle without `tick`, the delayed outputs, the scanline number and `glyph_byte` keep their values, whatever the other inputs do.
- R5: On a tick with `sl_gate` low, the scanline number moves right by one place and `sl_data` enters bit 3.
- R6: On a tick with `sl_gate` high, the scanline number is unchanged.
- R7: On each tick the RAM is read at address `{code, scanline}`. The code is the latch content before that edge, in bits 11..4. The scanline is the value after that tick's update, in bits 3..0. The byte appears on `glyph_byte` after that same edge.
- R8: `glyph_valid` is high for exactly the cycle that follows each tick edge, and low otherwise.
- R9: `row_load` latches `row_code` and `row_attr`, and the latch holds until the next load. A tick in the same cycle as a load uses the previous latch contents.
- R10: `cpu_we` writes `cpu_wdata` at `cpu_addr` in any cycle. If a write and a tick read hit the same address in the same cycle, the read returns the old byte, and the new byte is visible from the next read onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Character-time enable |
| row_load | input | 1 | Load strobe for code and attribute latch |
| row_code | input | 8 | Character code from the row buffer |
| row_attr | input | 2 | Bit 0 blink, bit 1 background |
| comp_blank | input | 1 | Composite blank |
| sl_gate | input | 1 | High holds the scanline number |
| sl_data | input | 1 | Serial scanline bit, enters the MSB |
| cpu_we | input | 1 | Pattern RAM write enable |
| cpu_addr | input | 12 | Pattern RAM write address |
| cpu_wdata | input | 8 | Pattern RAM write data |
| blink_out | output | 1 | Delayed blink |
| bkgnd_out | output | 1 | Delayed background |
| blank_out | output | 1 | Delayed blank |
| glyph_byte | output | 8 | Glyph byte read on the last tick |
| glyph_valid | output | 1 | One-cycle strobe after each tick |

## Verification
The bench goes after four corner cases.

- **Delay depth.** A delay line that is one stage short or long shows a blink, background or blank edge one tick early or late.
- **Scanline order.** A serial shifter that inserts at the wrong end, or that ignores the gate, reads a different row of the same glyph, and the expected pattern byte then differs.
- **Load and tick together.** A design that uses the new code, rather than the old one, when a load and a tick coincide reads the wrong glyph.
- **Write and read collision.** A RAM that passes write data through returns the new byte where the old one is expected.

Idle cycles with busy inputs catch any state that moves without a tick.

// File: rtl/glyph_seq_pkg.sv
package glyph_seq_pkg;

  // Lane numbering of the delay lines.
  localparam int LANE_BLINK = 0;
  localparam int LANE_BKGND = 1;
  localparam int LANE_BLANK = 2;
  localparam int NUM_LANES  = 3;

  // Attribute bits as they arrive with a character byte.
  typedef struct packed {
    logic bkgnd;
    logic blink;
  } attr_pair_t;

endpackage

// File: rtl/attr_delay_line.sv
module attr_delay_line #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] stage_q;

  // Insert at the top, tap the bottom into a registered output.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      dout    <= 1'b0;
    end else if (tick) begin
      dout    <= stage_q[0];
      stage_q <= {din, stage_q[DEPTH-1:1]};
    end
  end

  AST_DLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dout)); // R4

  AST_DLY_RESET: assert property (@(posedge clk)
    rst |=> (dout == 1'b0)); // R1

endmodule

// File: rtl/scanline_shifter.sv
module scanline_shifter #(
  parameter int SL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            gate,
  input  logic            sdata,
  output logic [SL_W-1:0] sl_q,
  output logic [SL_W-1:0] sl_next
);

  // Value the register takes at this edge; the RAM read uses it directly.
  always_comb begin
    sl_next = sl_q;
    if (tick && !gate) sl_next = {sdata, sl_q[SL_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) sl_q <= '0;
    else     sl_q <= sl_next;
  end

  AST_SL_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick && gate) |=> $stable(sl_q)); // R6

  AST_SL_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (tick && !gate) |=> (sl_q[SL_W-1] == $past(sdata))); // R5

  AST_SL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sl_q)); // R4

endmodule

// File: rtl/glyph_pattern_ram.sv
module glyph_pattern_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Read-first dual port: the read sees the contents from before this edge.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Output register with synchronous reset.
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R4

endmodule

// File: rtl/glyph_tick_seq.sv
module glyph_tick_seq
  import glyph_seq_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SL_W      = 4,
  parameter int GLYPH_W   = 8,
  parameter int DLY_DEPTH = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   row_load,
  input  logic [CODE_W-1:0]      row_code,
  input  logic [1:0]             row_attr,
  input  logic                   comp_blank,
  input  logic                   sl_gate,
  input  logic                   sl_data,
  input  logic                   cpu_we,
  input  logic [CODE_W+SL_W-1:0] cpu_addr,
  input  logic [GLYPH_W-1:0]     cpu_wdata,
  output logic                   blink_out,
  output logic                   bkgnd_out,
  output logic                   blank_out,
  output logic [GLYPH_W-1:0]     glyph_byte,
  output logic                   glyph_valid
);

  localparam int ADDR_W = CODE_W + SL_W;

  // Character byte latch.
  logic [CODE_W-1:0] code_q;
  attr_pair_t        attr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      attr_q <= '0;
    end else if (row_load) begin
      code_q <= row_code;
      attr_q <= attr_pair_t'(row_attr);
    end
  end

  // Delay lines, one per lane.
  logic [NUM_LANES-1:0] lane_in;
  logic [NUM_LANES-1:0] lane_out;

  always_comb begin
    lane_in             = '0;
    lane_in[LANE_BLINK] = attr_q.blink;
    lane_in[LANE_BKGND] = attr_q.bkgnd;
    lane_in[LANE_BLANK] = comp_blank;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    attr_delay_line #(.DEPTH(DLY_DEPTH)) u_dly (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .din  (lane_in[g]),
      .dout (lane_out[g])
    );
  end

  assign blink_out = lane_out[LANE_BLINK];
  assign bkgnd_out = lane_out[LANE_BKGND];
  assign blank_out = lane_out[LANE_BLANK];

  // Scanline number.
  logic [SL_W-1:0] sl_q;
  logic [SL_W-1:0] sl_next;

  scanline_shifter #(.SL_W(SL_W)) u_sl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .gate    (sl_gate),
    .sdata   (sl_data),
    .sl_q    (sl_q),
    .sl_next (sl_next)
  );

  // Pattern RAM.
  logic [ADDR_W-1:0] rd_addr;
  assign rd_addr = {code_q, sl_next};

  glyph_pattern_ram #(.ADDR_W(ADDR_W), .DATA_W(GLYPH_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (tick),
    .rd_addr (rd_addr),
    .rd_data (glyph_byte),
    .wr_en   (cpu_we),
    .wr_addr (cpu_addr),
    .wr_data (cpu_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) glyph_valid <= 1'b0;
    else     glyph_valid <= tick;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!glyph_valid && glyph_byte == '0 && !blink_out
             && !bkgnd_out && !blank_out)); // R1

  AST_GLYPH_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    !glyph_valid |-> $stable(glyph_byte)); // R8

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !row_load |=> $stable(code_q)); // R9

  AST_SCAN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    tick |=> ($past(rd_addr[SL_W-1:0]) == sl_q)); // R7

endmodule

// File: tb/glyph_tick_seq_test.sv
module glyph_tick_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, row_load = 1'b0, comp_blank = 1'b0;
  logic        sl_gate = 1'b0, sl_data = 1'b0, cpu_we = 1'b0;
  logic [7:0]  row_code = '0, cpu_wdata = '0;
  logic [1:0]  row_attr = '0;
  logic [11:0] cpu_addr = '0;
  logic        blink_out, bkgnd_out, blank_out, glyph_valid;
  logic [7:0]  glyph_byte;

  int errors = 0;
  int checks = 0;

  // Reference model state.
  logic [7:0] bmem [4096];
  logic [7:0] m_code = '0;
  logic [1:0] m_attr = '0;
  logic [2:0] m_dly [3];
  logic [2:0] m_out = '0;
  logic [3:0] m_sl = '0;
  logic [7:0] m_glyph = '0;
  logic       m_valid = 1'b0;

  always #10 clk = ~clk;

  glyph_tick_seq uut (
    .clk(clk), .rst(rst), .tick(tick), .row_load(row_load),
    .row_code(row_code), .row_attr(row_attr), .comp_blank(comp_blank),
    .sl_gate(sl_gate), .sl_data(sl_data), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .blink_out(blink_out),
    .bkgnd_out(bkgnd_out), .blank_out(blank_out), .glyph_byte(glyph_byte),
    .glyph_valid(glyph_valid)
  );

  function automatic logic [7:0] fill_pat(input logic [11:0] a);
    return {a[3:0], a[7:4] ^ a[11:8]};
  endfunction

  function automatic logic [3:0] next_sl(input logic [3:0] s, input logic g, input logic d);
    return g ? s : {d, s[3:1]};
  endfunction

  task automatic chk(input string tg, input string nm, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tg, nm, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tg);
    chk(tg, "blink_out", {7'd0, blink_out}, {7'd0, m_out[0]});
    chk(tg, "bkgnd_out", {7'd0, bkgnd_out}, {7'd0, m_out[1]});
    chk(tg, "blank_out", {7'd0, blank_out}, {7'd0, m_out[2]});
    chk(tg, "glyph_byte", glyph_byte, m_glyph);
    chk(tg, "glyph_valid", {7'd0, glyph_valid}, {7'd0, m_valid});
  endtask

  // Called at a negative edge: drive, take the edge, update the model, check.
  task automatic step(input string tg, input logic tk, input logic ld,
                      input logic [7:0] code, input logic [1:0] at,
                      input logic blk, input logic gt, input logic sd,
                      input logic we, input logic [11:0] wa, input logic [7:0] wd,
                      input logic do_chk);
    logic [3:0] sn;
    logic       lin;
    tick = tk; row_load = ld; row_code = code; row_attr = at;
    comp_blank = blk; sl_gate = gt; sl_data = sd;
    cpu_we = we; cpu_addr = wa; cpu_wdata = wd;
    @(posedge clk);
    if (tk) begin
      sn = next_sl(m_sl, gt, sd);
      m_glyph = bmem[{m_code, sn}];
      for (int l = 0; l < 3; l++) begin
        lin = (l == 0) ? m_attr[0] : (l == 1) ? m_attr[1] : blk;
        m_out[l] = m_dly[l][0];
        m_dly[l] = {lin, m_dly[l][2:1]};
      end
      m_sl = sn;
      m_valid = 1'b1;
    end else begin
      m_valid = 1'b0;
    end
    if (ld) begin m_code = code; m_attr = at; end
    if (we) bmem[wa] = wd;
    @(negedge clk);
    if (do_chk) check_all(tg);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [11:0] a;
    logic [7:0]  old_b;
    seed = $urandom(32'd4711);
    for (int l = 0; l < 3; l++) m_dly[l] = '0;
    for (int i = 0; i < 4096; i++) bmem[i] = 'x;

    // R1: reset clears every output.
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst = 1'b0;

    // R10: fill the pattern RAM with no ticks; R4 outputs stay put.
    for (int i = 0; i < 4096; i++)
      step("R4", 1'b0, 1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1,
           12'(i), fill_pat(12'(i)), (i % 64) == 0);

    // R9: load, then a tick with a simultaneous load of another code.
    step("R9", 1'b0, 1'b1, 8'h3c, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1);
    step("R9", 1'b1, 1'b1, 8'hc3, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1);
    step("R9", 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1);

    // R5: four gated-low ticks shift in 1,0,1,1.
    step("R5", 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, 1'b1);
    step("R5", 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
    step("R5", 1'b1, 1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0, 1'b1);
    step("R5", 1'b1, 1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0, 1'b1);

    // R6: gate high holds the scanline while data toggles.
    step("R6", 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1);
    step("R6", 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, '0, '0, 1'b1);

    // R2 / R3: single pulse walking through the delay lines.
    step("R2", 1'b0, 1'b1, 8'h11, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1);
    step("R3", 1'b1, 1'b1, 8'h11, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1);
    for (int k = 0; k < 4; k++)
      step("R2", 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1);

    // R4: idle cycles with busy inputs.
    for (int k = 0; k < 4; k++)
      step("R4", 1'b0, 1'b0, 8'hff, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0, 1'b1);

    // R10: write collides with the tick read at the same address.
    a = {m_code, m_sl};
    old_b = bmem[a];
    step("R10", 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, a, ~old_b, 1'b1);
    chk("R10", "old byte on collision", glyph_byte, old_b);
    step("R10", 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1);
    chk("R10", "new byte after collision", glyph_byte, ~old_b);

    // R7 / R8: constrained random traffic.
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step("R7", r[0] | r[1], r[2] & r[3], 8'($urandom), r[5:4], r[6], r[7] & r[8],
           r[9], (r[12:10] == 3'd0), 12'($urandom), 8'($urandom), 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule